// File: doc/BRIEF.md
# Paged Management-to-Word Register Bridge

This block lets a host that only speaks 16-bit clause-22 management transactions reach a 32-bit internal register space. It sits behind a management frame decoder and receives one strobe per transaction, carrying the target PHY address, the register number, the 16-bit write data and a read/write flag. It returns 16-bit read data and drives a plain internal 32-bit register bus.

The word address comes from three sources. A page register supplies the top nine bits of the word index. The low three bits of the PHY address supply the next three bits. The register number without its lowest bit supplies the bottom four bits. The page register sits at PHY 0x1F, register 0x10.

Each 32-bit word takes two management registers. The even register holds the low half and the odd register holds the high half. A write is committed when its low half arrives, after the high half has been staged. A read is issued when its low half is read, and the high half is captured at that moment so that the second access returns the matching half of the same word.

Top module: `mdio_page_bridge`

## Requirements
- R1: After synchronous reset, `mgmt_rdata` is zero, the page is zero, and `bus_we` and `bus_re` are low.
- R2: A write to PHY 0x1F, register 0x10 stores bits 8:0 of the data as the page. A read at that address returns the page zero-extended to 16 bits, one cycle after the strobe.
- R3: A data access is one whose PHY address lies in 0x10 to 0x17. Its word index is {page[8:0], phy[2:0], reg[4:1]}, and that index appears on `bus_addr` with the bus strobe.
- R4: A write to an odd register of a data access only stages the 16 bits. No bus write or bus read happens.
- R5: A write to an even register of a data access raises `bus_we` for exactly that strobe cycle. `bus_wdata` is {staged high half, write data}, and `bus_we` and `bus_re` are never high together.
- R6: A read of an even register of a data access raises `bus_re` for exactly that strobe cycle. One cycle later `mgmt_rdata` holds `bus_rdata[15:0]`, and the bridge keeps `bus_rdata[31:16]`.
- R7: A read of an odd register of a data access issues no bus read. It returns the high half kept by the last even-register read, even if the word has changed since then.
- R8: Accesses to any other PHY address, or to PHY 0x1F at a register other than 0x10, cause no bus activity and leave the page unchanged. Reads of them return zero.
- R9: `mgmt_rdata` changes only after a read strobe. Writes and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_valid | input | 1 | One-cycle strobe of a decoded management transaction |
| mgmt_write | input | 1 | 1 = write, 0 = read |
| mgmt_phy | input | 5 | PHY address of the transaction |
| mgmt_reg | input | 5 | Register number of the transaction |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Read data, valid from the cycle after a read strobe |
| bus_addr | output | 16 | Internal word index |
| bus_wdata | output | 32 | Internal write data |
| bus_we | output | 1 | Internal write strobe |
| bus_re | output | 1 | Internal read strobe |
| bus_rdata | input | 32 | Internal read data, combinational response to bus_addr |

## Verification
The hardest case to reach from the ports is a word that changes between the two halves of a read. Only this case shows whether the high half comes from the captured copy or from a fresh bus read. The bench gets there by doing an even-register read and then overwriting its own model word behind the bridge's back. It then does the odd-register read and expects the old upper half. A second hard case is an ignored access whose register number equals the page register's but whose PHY address does not, or the reverse. The bench aims such writes at the page register's neighbours and then reads the page back to confirm it is intact.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

    localparam int HALF_W    = 16;
    localparam int WORD_W    = 2 * HALF_W;
    localparam int PAGE_W    = 9;
    localparam int BLK_W     = 3;
    localparam int SLOT_W    = 4;
    localparam int IDX_W     = PAGE_W + BLK_W + SLOT_W;
    localparam int MADDR_W   = 5;

    localparam logic [MADDR_W-1:0] PAGE_PHY  = 5'h1F;
    localparam logic [MADDR_W-1:0] PAGE_REG  = 5'h10;
    localparam logic [MADDR_W-BLK_W-1:0] DATA_PHY_TAG = 2'b10;

    typedef enum logic [2:0] {
        ACC_IDLE = 3'd0,
        ACC_PAGE = 3'd1,
        ACC_LO   = 3'd2,
        ACC_HI   = 3'd3,
        ACC_VOID = 3'd4
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e           kind;
        logic                wr;
        logic [BLK_W-1:0]    blk;
        logic [SLOT_W-1:0]   slot;
        logic [HALF_W-1:0]   data;
    } mgmt_req_t;

    function automatic acc_kind_e classify(input logic [MADDR_W-1:0] phy,
                                           input logic [MADDR_W-1:0] regn);
        acc_kind_e k;
        if (phy == PAGE_PHY && regn == PAGE_REG)
            k = ACC_PAGE;
        else if (phy[MADDR_W-1:BLK_W] == DATA_PHY_TAG)
            k = regn[0] ? ACC_HI : ACC_LO;
        else
            k = ACC_VOID;
        return k;
    endfunction

    function automatic logic [IDX_W-1:0] word_index(input logic [PAGE_W-1:0] page,
                                                    input logic [BLK_W-1:0]  blk,
                                                    input logic [SLOT_W-1:0] slot);
        return {page, blk, slot};
    endfunction

endpackage

// File: rtl/mpb_decode.sv
module mpb_decode
    import mpb_pkg::*;
(
    input  logic               valid,
    input  logic               write,
    input  logic [MADDR_W-1:0] phy,
    input  logic [MADDR_W-1:0] regn,
    input  logic [HALF_W-1:0]  wdata,
    output mgmt_req_t          req
);
    always_comb begin
        req.kind = valid ? classify(phy, regn) : ACC_IDLE;
        req.wr   = valid & write;
        req.blk  = phy[BLK_W-1:0];
        req.slot = regn[SLOT_W:1];
        req.data = wdata;
    end
endmodule

// File: rtl/mpb_page_reg.sv
module mpb_page_reg
    import mpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mgmt_req_t         req,
    output logic [PAGE_W-1:0] page
);
    always_ff @(posedge clk) begin
        if (rst)
            page <= '0;
        else if (req.kind == ACC_PAGE && req.wr)
            page <= req.data[PAGE_W-1:0];
    end

    // R8: the page moves only on a write to its own address
    assert_page_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(req.kind == ACC_PAGE && req.wr) |=> $stable(page));

    // R2: a page write lands in the register the cycle after
    assert_page_load_R2: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_PAGE && req.wr) |=> page == $past(req.data[PAGE_W-1:0]));
endmodule

// File: rtl/mpb_word_stage.sv
module mpb_word_stage
    import mpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mgmt_req_t         req,
    input  logic [PAGE_W-1:0] page,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic [IDX_W-1:0]  bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    output logic [HALF_W-1:0] mgmt_rdata
);
    logic [HALF_W-1:0] hi_stage;
    logic [HALF_W-1:0] hi_keep;
    logic [HALF_W-1:0] page_view;

    assign page_view = HALF_W'(page);

    always_comb begin
        bus_addr  = word_index(page, req.blk, req.slot);
        bus_wdata = {hi_stage, req.data};
        bus_we    = (req.kind == ACC_LO) &  req.wr;
        bus_re    = (req.kind == ACC_LO) & ~req.wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_stage   <= '0;
            hi_keep    <= '0;
            mgmt_rdata <= '0;
        end else if (req.kind != ACC_IDLE) begin
            if (req.wr) begin
                if (req.kind == ACC_HI)
                    hi_stage <= req.data;
            end else begin
                unique case (req.kind)
                    ACC_LO: begin
                        mgmt_rdata <= bus_rdata[HALF_W-1:0];
                        hi_keep    <= bus_rdata[WORD_W-1:HALF_W];
                    end
                    ACC_HI:   mgmt_rdata <= hi_keep;
                    ACC_PAGE: mgmt_rdata <= page_view;
                    default:  mgmt_rdata <= '0;
                endcase
            end
        end
    end

    // R5: read and write strobes never overlap
    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_re));

    // R4: staging a high half never touches the bus
    assert_hi_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_HI) |-> (!bus_we && !bus_re));

    // R6: a low-half read returns the bus low half one cycle later
    assert_lo_read_R6: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_LO && !req.wr) |=> mgmt_rdata == $past(bus_rdata[HALF_W-1:0]));

    // R7: a high-half read returns what the preceding low read saw
    assert_hi_read_R7: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_HI && !req.wr) |=> mgmt_rdata == $past(hi_keep));

    // R8: ignored reads return zero
    assert_void_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_VOID && !req.wr) |=> mgmt_rdata == '0);

    // R9: read data holds across writes and idle cycles
    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_IDLE || req.wr) |=> $stable(mgmt_rdata));
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
    import mpb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mgmt_valid,
    input  logic               mgmt_write,
    input  logic [MADDR_W-1:0] mgmt_phy,
    input  logic [MADDR_W-1:0] mgmt_reg,
    input  logic [HALF_W-1:0]  mgmt_wdata,
    output logic [HALF_W-1:0]  mgmt_rdata,
    output logic [IDX_W-1:0]   bus_addr,
    output logic [WORD_W-1:0]  bus_wdata,
    output logic               bus_we,
    output logic               bus_re,
    input  logic [WORD_W-1:0]  bus_rdata
);
    mgmt_req_t         req;
    logic [PAGE_W-1:0] page;

    mpb_decode u_decode (
        .valid (mgmt_valid),
        .write (mgmt_write),
        .phy   (mgmt_phy),
        .regn  (mgmt_reg),
        .wdata (mgmt_wdata),
        .req   (req)
    );

    mpb_page_reg u_page (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .page (page)
    );

    mpb_word_stage u_stage (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .page       (page),
        .bus_rdata  (bus_rdata),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_re     (bus_re),
        .mgmt_rdata (mgmt_rdata)
    );

    // R3: bus strobes only ever carry data-range PHY addresses
    assert_data_range_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we || bus_re) |-> (mgmt_phy[4:3] == 2'b10 && !mgmt_reg[0]));
endmodule

// File: tb/sim_mdio_page_bridge.sv
module sim_mdio_page_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mgmt_valid = 1'b0;
    logic        mgmt_write = 1'b0;
    logic [4:0]  mgmt_phy = '0;
    logic [4:0]  mgmt_reg = '0;
    logic [15:0] mgmt_wdata = '0;
    logic [15:0] mgmt_rdata;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic        bus_re;
    logic [31:0] bus_rdata;

    logic [31:0] mem [64];
    int          we_count = 0;
    int          re_count = 0;
    logic [15:0] last_waddr = '0;
    logic [31:0] last_wdata = '0;
    logic [15:0] last_raddr = '0;
    int          checks = 0;
    int          fails = 0;

    always #10 clk = ~clk;

    assign bus_rdata = mem[bus_addr[5:0]];

    mdio_page_bridge u0 (
        .clk (clk), .rst (rst),
        .mgmt_valid (mgmt_valid), .mgmt_write (mgmt_write),
        .mgmt_phy (mgmt_phy), .mgmt_reg (mgmt_reg),
        .mgmt_wdata (mgmt_wdata), .mgmt_rdata (mgmt_rdata),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_we (bus_we), .bus_re (bus_re), .bus_rdata (bus_rdata)
    );

    always @(posedge clk) begin
        if (!rst && bus_we) begin
            mem[bus_addr[5:0]] <= bus_wdata;
            we_count   = we_count + 1;
            last_waddr = bus_addr;
            last_wdata = bus_wdata;
        end
        if (!rst && bus_re) begin
            re_count   = re_count + 1;
            last_raddr = bus_addr;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mwrite(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
        @(negedge clk);
        mgmt_valid = 1'b1; mgmt_write = 1'b1;
        mgmt_phy = phy; mgmt_reg = rg; mgmt_wdata = d;
        @(negedge clk);
        mgmt_valid = 1'b0; mgmt_write = 1'b0;
    endtask

    task automatic mread(input logic [4:0] phy, input logic [4:0] rg, output logic [15:0] d);
        @(negedge clk);
        mgmt_valid = 1'b1; mgmt_write = 1'b0;
        mgmt_phy = phy; mgmt_reg = rg;
        @(negedge clk);
        mgmt_valid = 1'b0;
        d = mgmt_rdata;
    endtask

    function automatic logic [15:0] idx(input logic [8:0] pg, input logic [4:0] phy,
                                        input logic [4:0] rg);
        return {pg, phy[2:0], rg[4:1]};
    endfunction

    task automatic t_reset;
        logic [15:0] d;
        check(mgmt_rdata == 16'h0, "R1 rdata", 32'(mgmt_rdata), 0);
        check(!bus_we && !bus_re, "R1 strobes", {bus_we, bus_re}, 0);
        mread(5'h1F, 5'h10, d);
        check(d == 16'h0, "R1 page zero", 32'(d), 0);
    endtask

    task automatic t_page;
        logic [15:0] d;
        mwrite(5'h1F, 5'h10, 16'hFFAB);
        mread(5'h1F, 5'h10, d);
        check(d == 16'h01AB, "R2 page readback", 32'(d), 32'h01AB);
    endtask

    task automatic t_write_word;
        int w0;
        w0 = we_count;
        mwrite(5'h15, 5'h0B, 16'hDEAD);
        check(we_count == w0, "R4 staged no write", we_count, w0);
        mwrite(5'h15, 5'h0A, 16'hBEEF);
        check(we_count == w0 + 1, "R5 one write", we_count, w0 + 1);
        check(last_wdata == 32'hDEADBEEF, "R5 wdata", last_wdata, 32'hDEADBEEF);
        check(last_waddr == idx(9'h1AB, 5'h15, 5'h0A), "R3 waddr",
              32'(last_waddr), 32'(idx(9'h1AB, 5'h15, 5'h0A)));
    endtask

    task automatic t_read_word;
        logic [15:0] d;
        int r0;
        r0 = re_count;
        mread(5'h15, 5'h0A, d);
        check(d == 16'hBEEF, "R6 low half", 32'(d), 32'hBEEF);
        check(re_count == r0 + 1, "R6 one read", re_count, r0 + 1);
        check(last_raddr == idx(9'h1AB, 5'h15, 5'h0A), "R3 raddr",
              32'(last_raddr), 32'(idx(9'h1AB, 5'h15, 5'h0A)));
        mread(5'h15, 5'h0B, d);
        check(d == 16'hDEAD, "R7 high half", 32'(d), 32'hDEAD);
        check(re_count == r0 + 1, "R7 no bus read", re_count, r0 + 1);
    endtask

    task automatic t_consistency;
        logic [15:0] d;
        logic [15:0] a;
        a = idx(9'h1AB, 5'h15, 5'h0A);
        mread(5'h15, 5'h0A, d);
        mem[a[5:0]] = 32'h12345678;
        mread(5'h15, 5'h0B, d);
        check(d == 16'hDEAD, "R7 held across change", 32'(d), 32'hDEAD);
        mread(5'h15, 5'h0A, d);
        check(d == 16'h5678, "R6 fresh low", 32'(d), 32'h5678);
    endtask

    task automatic t_ignored;
        logic [15:0] d;
        int w0;
        int r0;
        w0 = we_count; r0 = re_count;
        mwrite(5'h05, 5'h00, 16'h1111);
        mwrite(5'h1F, 5'h11, 16'h0055);
        mwrite(5'h1E, 5'h10, 16'h0066);
        mwrite(5'h18, 5'h0A, 16'h2222);
        check(we_count == w0, "R8 no bus write", we_count, w0);
        mread(5'h18, 5'h0A, d);
        check(d == 16'h0, "R8 read zero 0x18", 32'(d), 0);
        mread(5'h1F, 5'h11, d);
        check(d == 16'h0, "R8 read zero 0x1F/0x11", 32'(d), 0);
        check(re_count == r0, "R8 no bus read", re_count, r0);
        mread(5'h1F, 5'h10, d);
        check(d == 16'h01AB, "R8 page intact", 32'(d), 32'h01AB);
    endtask

    task automatic t_hold;
        logic [15:0] d;
        mread(5'h1F, 5'h10, d);
        mwrite(5'h12, 5'h03, 16'h7777);
        mwrite(5'h1F, 5'h10, 16'h0000);
        repeat (3) @(negedge clk);
        check(mgmt_rdata == 16'h01AB, "R9 rdata held", 32'(mgmt_rdata), 32'h01AB);
    endtask

    task automatic t_other_blocks;
        mwrite(5'h10, 5'h01, 16'hA5A5);
        mwrite(5'h10, 5'h00, 16'h5A5A);
        check(last_waddr == 16'h0000, "R3 base index", 32'(last_waddr), 0);
        check(last_wdata == 32'hA5A55A5A, "R5 wdata base", last_wdata, 32'hA5A55A5A);
        mwrite(5'h1F, 5'h10, 16'h0100);
        mwrite(5'h17, 5'h1F, 16'h0F0F);
        mwrite(5'h17, 5'h1E, 16'hF0F0);
        check(last_waddr == idx(9'h100, 5'h17, 5'h1E), "R3 top index",
              32'(last_waddr), 32'(idx(9'h100, 5'h17, 5'h1E)));
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_page();
        t_write_word();
        t_read_word();
        t_consistency();
        t_ignored();
        t_hold();
        t_other_blocks();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule